// File: doc/BRIEF.md
# Framebuffer Rectangle Fill and Copy Engine

The engine draws into a byte-addressed framebuffer through one byte-wide memory port. It knows two commands. A solid fill paints a rectangle with a colour word. A rectangle copy moves a block of pixels from a source corner to a destination corner, and the source and destination may overlap. Pixels are packed at 1 to 4 bytes each (`cfg_bypp`), and one screen line is `cfg_bypp * cfg_scr_w` bytes long. After each command the destination rectangle is stored in a dirty-rectangle ring. A display path drains the ring later and redraws those areas, with each rectangle clamped to the screen on the way out.

The control is one state machine with these states:
- `ST_IDLE` waits for a command.
- `ST_FILL_FIRST` writes the first fill row byte by byte.
- `ST_FILL_RD` and `ST_FILL_WR` alternate, reading a byte of the first row and writing it one or more pitches further down.
- `ST_COPY_RD` and `ST_COPY_WR` alternate, reading a source byte and writing it to the destination.
- `ST_PUSH` stores the destination rectangle in the ring.

The transitions are:
- `ST_IDLE` goes to `ST_PUSH` when the width or height is zero, to `ST_COPY_RD` for a copy, and to `ST_FILL_FIRST` for a fill.
- `ST_FILL_FIRST` stays in place until the last byte of the row. It then goes to `ST_PUSH` for a one-row fill, and to `ST_FILL_RD` otherwise.
- `ST_FILL_RD` always goes to `ST_FILL_WR`, and `ST_COPY_RD` always goes to `ST_COPY_WR`.
- `ST_FILL_WR` and `ST_COPY_WR` go to `ST_PUSH` after the last byte of the last row. Otherwise they return to their read state.
- `ST_PUSH` always returns to `ST_IDLE`.

Top module: `rect_blit_engine`

## Requirements
- R1: Pixel (x, y) starts at byte address `bypp*x + (bypp*scr_w)*y`. A row of w pixels covers `bypp*w` consecutive bytes, and each access on the memory port moves one byte.
- R2: A fill writes byte b of its first row with bits `[8*(b mod bypp) +: 8]` of `cmd_colour`. The colour is taken least significant byte first and repeats every bypp bytes.
- R3: Each later fill row has the same bytes as the first row and lies one pitch below the row before it. These bytes are read back from the first row.
- R4: When the destination y is greater than the source y, a copy walks its rows from the last to the first. Otherwise it walks from the first row to the last. In both cases the destination ends up holding the source contents as they were before the command.
- R5: When the source and destination are on the same row and the destination x is greater than the source x, each row is copied from right to left, so a copy that overlaps sideways is also correct.
- R6: After every command, including one of zero size, the rectangle (dx, dy, w, h) is pushed into the ring (x, y for a fill). `drain_valid` is high while the ring holds entries. `drain_pop` removes the head, and entries come out in push order. The ring has `RING_DEPTH` entries (a power of two) and its indices wrap modulo the depth.
- R7: While `drain_inval` is high, the ring is emptied by setting its read index to its write index. `drain_valid` is low in that cycle and stays low until the next push.
- R8: A drained rectangle is clamped to the screen. If x+w > scr_w, x becomes min(x, scr_w) and w becomes scr_w − x. y and h are clamped the same way against scr_h.
- R9: A command with zero width or zero height makes no memory access.
- R10: `busy` rises in the cycle after a command is accepted. It stays high for exactly wb+2·wb·(h−1)+1 cycles for a fill, 2·wb·h+1 cycles for a copy, and 1 cycle for a zero-size command (wb = bypp·w). While busy is high, `cmd_valid` is ignored.
- R11: During reset, `busy`, `mem_en` and `drain_valid` are low.
- R12: Read data on `mem_rdata` appears one cycle after the enabled read cycle. Each copied byte takes one read cycle followed by one write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_bypp | input | 3 | Bytes per pixel, 1 to 4 |
| cfg_scr_w | input | CW | Screen width in pixels |
| cfg_scr_h | input | CW | Screen height in lines |
| cmd_valid | input | 1 | Command present; taken when idle |
| cmd_copy | input | 1 | 1 = copy, 0 = fill |
| cmd_colour | input | 32 | Fill colour word |
| cmd_sx | input | CW | Copy source x |
| cmd_sy | input | CW | Copy source y |
| cmd_dx | input | CW | Destination x (fill x) |
| cmd_dy | input | CW | Destination y (fill y) |
| cmd_w | input | CW | Rectangle width in pixels |
| cmd_h | input | CW | Rectangle height in lines |
| busy | output | 1 | Command in progress |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, one cycle after the read |
| drain_inval | input | 1 | Discard all ring entries |
| drain_pop | input | 1 | Remove the head entry |
| drain_valid | output | 1 | Ring head is present |
| drain_x | output | CW | Clamped head x |
| drain_y | output | CW | Clamped head y |
| drain_w | output | CW | Clamped head width |
| drain_h | output | CW | Clamped head height |

## Verification
The bench sweeps all four pixel sizes. For each size it runs fills and copies that overlap downward, upward, to the right and to the left, and compares the whole memory against a bench model that copies from a snapshot. A wrong vertical or horizontal walk order would smear repeated source bytes across the destination. A colour byte ordering off by one byte position, or the wrong repeat length, shows up as a shifted pattern for pixel sizes above one. The bench also checks the following:
- Zero-size commands must leave the write count unchanged and still produce a ring entry.
- Rectangles that run past the right or bottom edge, or start beyond it, must drain clamped.
- A command offered while the engine is busy, or a ring invalidate, must leave no trace at all.

// File: rtl/rect_blit_pkg.sv
package rect_blit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL_FIRST,
        ST_FILL_RD,
        ST_FILL_WR,
        ST_COPY_RD,
        ST_COPY_WR,
        ST_PUSH
    } blit_state_e;

    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned COLOUR_W = 32;

endpackage

// File: rtl/rect_blit_addr_gen.sv
module rect_blit_addr_gen #(
    parameter int CW = 12,
    parameter int AW = 24
) (
    input  logic [2:0]    bypp,
    input  logic [AW-1:0] pitch,
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    output logic [AW-1:0] addr
);
    // Byte offset of the pixel column plus whole lines above it.
    assign addr = AW'(bypp) * AW'(x) + pitch * AW'(y);
endmodule

// File: rtl/rect_blit_axis_clamp.sv
module rect_blit_axis_clamp #(
    parameter int CW = 12
) (
    input  logic [CW-1:0] lim,
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] len,
    output logic [CW-1:0] pos_c,
    output logic [CW-1:0] len_c
);
    logic [CW:0] end_pos;

    assign end_pos = {1'b0, pos} + {1'b0, len};

    always_comb begin
        if (end_pos > {1'b0, lim}) begin
            pos_c = (pos < lim) ? pos : lim;
            len_c = lim - pos_c;
        end else begin
            pos_c = pos;
            len_c = len;
        end
    end
endmodule

// File: rtl/rect_blit_dirty_ring.sv
module rect_blit_dirty_ring #(
    parameter int CW    = 12,
    parameter int DEPTH = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [4*CW-1:0] push_rect,
    input  logic            pop,
    input  logic            discard,
    output logic            valid,
    output logic [4*CW-1:0] head_rect
);
    // DEPTH must be a power of two: indices wrap by dropping high bits.
    localparam int PW = $clog2(DEPTH);
    localparam int EW = 4 * CW;

    logic [EW-1:0] slots [DEPTH];
    logic [PW-1:0] wr_ptr;
    logic [PW-1:0] rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            slots[wr_ptr] <= push_rect;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (discard) begin
                rd_ptr <= wr_ptr;
            end else if (pop && valid) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    assign valid     = (rd_ptr != wr_ptr) && !discard;
    assign head_rect = slots[rd_ptr];
endmodule

// File: rtl/rect_blit_engine.sv
module rect_blit_engine
    import rect_blit_pkg::*;
#(
    parameter int CW         = 12,
    parameter int AW         = 24,
    parameter int RING_DEPTH = 512
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_bypp,
    input  logic [CW-1:0] cfg_scr_w,
    input  logic [CW-1:0] cfg_scr_h,
    input  logic          cmd_valid,
    input  logic          cmd_copy,
    input  logic [31:0]   cmd_colour,
    input  logic [CW-1:0] cmd_sx,
    input  logic [CW-1:0] cmd_sy,
    input  logic [CW-1:0] cmd_dx,
    input  logic [CW-1:0] cmd_dy,
    input  logic [CW-1:0] cmd_w,
    input  logic [CW-1:0] cmd_h,
    output logic          busy,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    input  logic [7:0]    mem_rdata,
    input  logic          drain_inval,
    input  logic          drain_pop,
    output logic          drain_valid,
    output logic [CW-1:0] drain_x,
    output logic [CW-1:0] drain_y,
    output logic [CW-1:0] drain_w,
    output logic [CW-1:0] drain_h
);
    localparam int BW = CW + 3;   // byte count of one rectangle row

    blit_state_e state, state_nx;

    logic [COLOUR_W-1:0] colour_q;
    logic [COLOUR_W-1:0] colour_sh;
    logic [1:0]          phase;
    logic [2:0]          bypp_q;
    logic [AW-1:0]       pitch_q;
    logic [BW-1:0]       wb_q;
    logic [BW-1:0]       col;
    logic [CW-1:0]       rows_q;
    logic [AW-1:0]       src_row;
    logic [AW-1:0]       dst_row;
    logic [AW-1:0]       row0;
    logic                up_q;
    logic                rev_q;
    logic [CW-1:0]       rx_q, ry_q, rw_q, rh_q;

    logic                accept;
    logic                zero_sz;
    logic                up_c;
    logic                rev_c;
    logic [CW-1:0]       src_y0, dst_y0;
    logic [AW-1:0]       pitch_c;
    logic [AW-1:0]       src_addr_c, dst_addr_c;
    logic                col_last, row_last, phase_last;
    logic [BW-1:0]       boff;
    logic                push_w;

    // ---------------- command decode ----------------
    assign accept  = (state == ST_IDLE) && cmd_valid;
    assign zero_sz = (cmd_w == '0) || (cmd_h == '0);
    assign up_c    = cmd_copy && (cmd_dy > cmd_sy);
    assign rev_c   = cmd_copy && (cmd_dy == cmd_sy) && (cmd_dx > cmd_sx);
    assign src_y0  = up_c ? (cmd_sy + cmd_h - 1'b1) : cmd_sy;
    assign dst_y0  = up_c ? (cmd_dy + cmd_h - 1'b1) : cmd_dy;
    assign pitch_c = AW'(cfg_bypp) * AW'(cfg_scr_w);

    rect_blit_addr_gen #(.CW(CW), .AW(AW)) src_gen_i (
        .bypp (cfg_bypp),
        .pitch(pitch_c),
        .x    (cmd_sx),
        .y    (src_y0),
        .addr (src_addr_c)
    );

    rect_blit_addr_gen #(.CW(CW), .AW(AW)) dst_gen_i (
        .bypp (cfg_bypp),
        .pitch(pitch_c),
        .x    (cmd_dx),
        .y    (dst_y0),
        .addr (dst_addr_c)
    );

    assign col_last   = (col == wb_q - 1'b1);
    assign row_last   = (rows_q == CW'(1));
    assign phase_last = ({1'b0, phase} == (bypp_q - 3'd1));
    assign boff       = rev_q ? (wb_q - 1'b1 - col) : col;

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (zero_sz)       state_nx = ST_PUSH;
                    else if (cmd_copy) state_nx = ST_COPY_RD;
                    else               state_nx = ST_FILL_FIRST;
                end
            end
            ST_FILL_FIRST: begin
                if (col_last) state_nx = row_last ? ST_PUSH : ST_FILL_RD;
            end
            ST_FILL_RD: state_nx = ST_FILL_WR;
            ST_FILL_WR: state_nx = (col_last && row_last) ? ST_PUSH : ST_FILL_RD;
            ST_COPY_RD: state_nx = ST_COPY_WR;
            ST_COPY_WR: state_nx = (col_last && row_last) ? ST_PUSH : ST_COPY_RD;
            ST_PUSH:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register and datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            colour_q  <= '0;
            colour_sh <= '0;
            phase     <= '0;
            bypp_q    <= 3'd1;
            pitch_q   <= '0;
            wb_q      <= '0;
            col       <= '0;
            rows_q    <= '0;
            src_row   <= '0;
            dst_row   <= '0;
            row0      <= '0;
            up_q      <= 1'b0;
            rev_q     <= 1'b0;
            rx_q      <= '0;
            ry_q      <= '0;
            rw_q      <= '0;
            rh_q      <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        colour_q  <= cmd_colour;
                        colour_sh <= cmd_colour;
                        phase     <= '0;
                        bypp_q    <= cfg_bypp;
                        pitch_q   <= pitch_c;
                        wb_q      <= BW'(cmd_w) * BW'(cfg_bypp);
                        col       <= '0;
                        rows_q    <= cmd_h;
                        src_row   <= src_addr_c;
                        dst_row   <= dst_addr_c;
                        row0      <= dst_addr_c;
                        up_q      <= up_c;
                        rev_q     <= rev_c;
                        rx_q      <= cmd_dx;
                        ry_q      <= cmd_dy;
                        rw_q      <= cmd_w;
                        rh_q      <= cmd_h;
                    end
                end
                ST_FILL_FIRST: begin
                    if (phase_last) begin
                        phase     <= '0;
                        colour_sh <= colour_q;
                    end else begin
                        phase     <= phase + 1'b1;
                        colour_sh <= {colour_sh[7:0], colour_sh[COLOUR_W-1:8]};
                    end
                    if (col_last) begin
                        col     <= '0;
                        rows_q  <= rows_q - 1'b1;
                        dst_row <= dst_row + pitch_q;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_FILL_WR: begin
                    if (col_last) begin
                        col     <= '0;
                        rows_q  <= rows_q - 1'b1;
                        dst_row <= dst_row + pitch_q;
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_COPY_WR: begin
                    if (col_last) begin
                        col    <= '0;
                        rows_q <= rows_q - 1'b1;
                        if (up_q) begin
                            src_row <= src_row - pitch_q;
                            dst_row <= dst_row - pitch_q;
                        end else begin
                            src_row <= src_row + pitch_q;
                            dst_row <= dst_row + pitch_q;
                        end
                    end else begin
                        col <= col + 1'b1;
                    end
                end
                ST_FILL_RD, ST_COPY_RD, ST_PUSH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        push_w    = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: busy = 1'b0;
            ST_FILL_FIRST: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_row + AW'(col);
                mem_wdata = colour_sh[7:0];
            end
            ST_FILL_RD: begin
                mem_en   = 1'b1;
                mem_addr = row0 + AW'(col);
            end
            ST_FILL_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_row + AW'(col);
                mem_wdata = mem_rdata;
            end
            ST_COPY_RD: begin
                mem_en   = 1'b1;
                mem_addr = src_row + AW'(boff);
            end
            ST_COPY_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dst_row + AW'(boff);
                mem_wdata = mem_rdata;
            end
            ST_PUSH: push_w = 1'b1;
            default: busy = 1'b0;
        endcase
    end

    // ---------------- dirty ring and drain clamp ----------------
    logic [4*CW-1:0] head_rect;
    logic [CW-1:0]   hx, hy, hw, hh;

    rect_blit_dirty_ring #(.CW(CW), .DEPTH(RING_DEPTH)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push_w),
        .push_rect({rx_q, ry_q, rw_q, rh_q}),
        .pop      (drain_pop),
        .discard  (drain_inval),
        .valid    (drain_valid),
        .head_rect(head_rect)
    );

    assign {hx, hy, hw, hh} = head_rect;

    rect_blit_axis_clamp #(.CW(CW)) clamp_x_i (
        .lim(cfg_scr_w), .pos(hx), .len(hw), .pos_c(drain_x), .len_c(drain_w)
    );

    rect_blit_axis_clamp #(.CW(CW)) clamp_y_i (
        .lim(cfg_scr_h), .pos(hy), .len(hh), .pos_c(drain_y), .len_c(drain_h)
    );
endmodule

// File: rtl/rect_blit_checker.sv
module rect_blit_checker #(
    parameter int CW = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          cmd_valid,
    input logic [CW-1:0] cmd_w,
    input logic [CW-1:0] cmd_h,
    input logic          mem_en,
    input logic          push,
    input logic          drain_inval,
    input logic          drain_valid,
    input logic [CW-1:0] cfg_scr_w,
    input logic [CW-1:0] cfg_scr_h,
    input logic [CW-1:0] drain_x,
    input logic [CW-1:0] drain_y,
    input logic [CW-1:0] drain_w,
    input logic [CW-1:0] drain_h
);
    // R9: a zero-size command goes straight to the push, with no access
    a_r9_zero_no_access: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && (cmd_w == '0 || cmd_h == '0)) |=> !mem_en);

    // R10: memory is touched only while a command is in progress
    a_r10_access_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> busy);

    // R10: the ring push is the last busy cycle
    a_r10_push_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> !busy);

    // R7: an invalidate with no push in the same cycle leaves the ring empty
    a_r7_inval_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_inval && !push) |=> !drain_valid);

    // R8: drained rectangles lie inside the screen
    a_r8_clamp_x: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> (({1'b0, drain_x} + {1'b0, drain_w}) <= {1'b0, cfg_scr_w}));

    a_r8_clamp_y: assert property (@(posedge clk) disable iff (!rst_n)
        drain_valid |-> (({1'b0, drain_y} + {1'b0, drain_h}) <= {1'b0, cfg_scr_h}));
endmodule

bind rect_blit_engine rect_blit_checker #(.CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cmd_valid  (cmd_valid),
    .cmd_w      (cmd_w),
    .cmd_h      (cmd_h),
    .mem_en     (mem_en),
    .push       (push_w),
    .drain_inval(drain_inval),
    .drain_valid(drain_valid),
    .cfg_scr_w  (cfg_scr_w),
    .cfg_scr_h  (cfg_scr_h),
    .drain_x    (drain_x),
    .drain_y    (drain_y),
    .drain_w    (drain_w),
    .drain_h    (drain_h)
);

// File: tb/rect_blit_engine_tb_top.sv
`timescale 1ns/1ps
module rect_blit_engine_tb_top;
    localparam int CW = 12;
    localparam int AW = 24;
    localparam int MEMSZ = 4096;
    localparam int SW = 16;
    localparam int SH = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    cfg_bypp = 3'd1;
    logic [CW-1:0] cfg_scr_w = CW'(SW);
    logic [CW-1:0] cfg_scr_h = CW'(SH);
    logic          cmd_valid = 1'b0;
    logic          cmd_copy = 1'b0;
    logic [31:0]   cmd_colour = '0;
    logic [CW-1:0] cmd_sx = '0, cmd_sy = '0, cmd_dx = '0, cmd_dy = '0;
    logic [CW-1:0] cmd_w = '0, cmd_h = '0;
    logic          busy, mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [7:0]    mem_rdata;
    logic          drain_inval = 1'b0;
    logic          drain_pop = 1'b0;
    logic          drain_valid;
    logic [CW-1:0] drain_x, drain_y, drain_w, drain_h;

    always #2.5 clk = ~clk;

    rect_blit_engine #(.CW(CW), .AW(AW), .RING_DEPTH(512)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_bypp(cfg_bypp), .cfg_scr_w(cfg_scr_w),
        .cfg_scr_h(cfg_scr_h), .cmd_valid(cmd_valid), .cmd_copy(cmd_copy),
        .cmd_colour(cmd_colour), .cmd_sx(cmd_sx), .cmd_sy(cmd_sy),
        .cmd_dx(cmd_dx), .cmd_dy(cmd_dy), .cmd_w(cmd_w), .cmd_h(cmd_h),
        .busy(busy), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .drain_inval(drain_inval),
        .drain_pop(drain_pop), .drain_valid(drain_valid), .drain_x(drain_x),
        .drain_y(drain_y), .drain_w(drain_w), .drain_h(drain_h)
    );

    // Byte memory with one cycle read latency
    logic [7:0] mem_m [MEMSZ];
    logic [7:0] ref_m [MEMSZ];
    logic [7:0] snap_m [MEMSZ];
    logic [7:0] rdq = '0;
    int         wr_count = 0;

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem_m[mem_addr[11:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
            end
            rdq <= mem_m[mem_addr[11:0]];
        end
    end
    assign mem_rdata = rdq;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int busy_cycles;

    int qx[64], qy[64], qw[64], qh[64];
    int qn = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_mem(input string req);
        int bad_addr;
        bad_addr = -1;
        for (int i = 0; i < 1024; i++) begin
            if (bad_addr < 0 && mem_m[i] !== ref_m[i]) bad_addr = i;
        end
        if (bad_addr < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, {req, " (byte at first bad address)"},
                 int'(mem_m[bad_addr]), int'(ref_m[bad_addr]));
    endtask

    task automatic ref_fill(input int bp, input logic [31:0] c,
                            input int x, input int y, input int w, input int h);
        int pitch;
        pitch = bp * SW;
        for (int r = 0; r < h; r++)
            for (int b = 0; b < bp * w; b++)
                ref_m[bp * x + pitch * (y + r) + b] = c[8 * (b % bp) +: 8];
    endtask

    task automatic ref_copy(input int bp, input int sx, input int sy, input int dx,
                            input int dy, input int w, input int h);
        int pitch;
        pitch = bp * SW;
        for (int i = 0; i < MEMSZ; i++) snap_m[i] = ref_m[i];
        for (int r = 0; r < h; r++)
            for (int b = 0; b < bp * w; b++)
                ref_m[bp * dx + pitch * (dy + r) + b] = snap_m[bp * sx + pitch * (sy + r) + b];
    endtask

    task automatic run_cmd(input bit cp, input logic [31:0] c, input int sx, input int sy,
                           input int dx, input int dy, input int w, input int h,
                           input bit poke_busy, input string req);
        int bp, wb, exp_busy, wc0;
        bp = int'(cfg_bypp);
        wb = bp * w;
        wc0 = wr_count;
        if (w == 0 || h == 0) exp_busy = 1;
        else if (cp) exp_busy = 2 * wb * h + 1;
        else exp_busy = wb + 2 * wb * (h - 1) + 1;
        @(negedge clk);
        cmd_copy = cp; cmd_colour = c;
        cmd_sx = CW'(sx); cmd_sy = CW'(sy); cmd_dx = CW'(dx); cmd_dy = CW'(dy);
        cmd_w = CW'(w); cmd_h = CW'(h);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        busy_cycles = 0;
        if (poke_busy) begin
            // R10: a second command offered while busy must be dropped
            cmd_copy = 1'b0; cmd_colour = 32'hFFFF_FFFF;
            cmd_dx = '0; cmd_dy = '0; cmd_w = CW'(SW); cmd_h = CW'(SH);
            cmd_valid = 1'b1;
        end
        while (busy) begin
            busy_cycles++;
            @(negedge clk);
            if (busy_cycles == 2) cmd_valid = 1'b0;
        end
        cmd_valid = 1'b0;
        if (cp) ref_copy(bp, sx, sy, dx, dy, w, h);
        else ref_fill(bp, c, dx, dy, w, h);
        qx[qn] = dx; qy[qn] = dy; qw[qn] = w; qh[qn] = h; qn++;
        check_mem(req);
        chk(busy_cycles == exp_busy, "R10 busy length", busy_cycles, exp_busy);
        if (w == 0 || h == 0) chk(wr_count == wc0, "R9 zero-size writes", wr_count - wc0, 0);
    endtask

    task automatic drain_check();
        int ex, ey, ew, eh;
        for (int i = 0; i < qn; i++) begin
            @(negedge clk);
            ex = qx[i]; ew = qw[i]; ey = qy[i]; eh = qh[i];
            if (ex + ew > SW) begin ex = (ex < SW) ? ex : SW; ew = SW - ex; end
            if (ey + eh > SH) begin ey = (ey < SH) ? ey : SH; eh = SH - ey; end
            chk(drain_valid === 1'b1, "R6 ring entry present", int'(drain_valid), 1);
            chk(int'(drain_x) == ex && int'(drain_w) == ew, "R6/R8 drained x,w",
                int'(drain_x) * 1000 + int'(drain_w), ex * 1000 + ew);
            chk(int'(drain_y) == ey && int'(drain_h) == eh, "R6/R8 drained y,h",
                int'(drain_y) * 1000 + int'(drain_h), ey * 1000 + eh);
            drain_pop = 1'b1;
            @(negedge clk);
            drain_pop = 1'b0;
        end
        @(negedge clk);
        chk(drain_valid === 1'b0, "R6 ring empty after drain", int'(drain_valid), 0);
        qn = 0;
    endtask

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin
            mem_m[i] = 8'((i * 7 + 3) & 255);
            ref_m[i] = 8'((i * 7 + 3) & 255);
        end
        repeat (4) @(negedge clk);
        // R11: reset state
        chk(busy === 1'b0 && mem_en === 1'b0 && drain_valid === 1'b0, "R11 reset outputs",
            int'({busy, mem_en, drain_valid}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int bp = 1; bp <= 4; bp++) begin
            cfg_bypp = 3'(bp);
            run_cmd(0, 32'h4433_2211 + 32'(bp), 0, 0, 1, 1, 5, 3, 0, "R1/R2/R3 fill");
            run_cmd(0, 32'hA5C3_0F96, 0, 0, 0, 0, 16, 1, 0, "R1/R2 one-row fill");
            run_cmd(1, 0, 1, 1, 3, 2, 5, 3, 0, "R4/R12 copy overlap downward");
            run_cmd(1, 0, 3, 2, 2, 0, 5, 3, 0, "R4/R12 copy overlap upward");
            run_cmd(1, 0, 0, 4, 3, 4, 8, 2, 0, "R5 same-row copy to the right");
            run_cmd(1, 0, 4, 5, 1, 5, 8, 2, 0, "R5 same-row copy to the left");
            run_cmd(0, 32'h1234_5678, 0, 0, 2, 2, 4, 0, 0, "R9 zero-height fill");
            run_cmd(1, 0, 0, 0, 5, 5, 0, 3, 0, "R9 zero-width copy");
            run_cmd(0, 32'h0BAD_F00D, 0, 0, 12, 6, 10, 1, 0, "R8 fill past right edge");
            run_cmd(0, 32'h7788_99AA, 0, 0, 0, 6, 2, 5, 0, "R8 fill past bottom edge");
            run_cmd(0, 32'h0, 0, 0, 20, 3, 2, 0, 0, "R8 rectangle beyond screen");
            drain_check();
        end

        // R10: command offered while busy is ignored
        cfg_bypp = 3'd2;
        run_cmd(0, 32'h0000_C1C2, 0, 0, 2, 3, 6, 3, 1, "R10 busy command ignored");
        drain_check();

        // R7: invalidate discards pending rectangles
        run_cmd(0, 32'h5566_7788, 0, 0, 1, 1, 2, 2, 0, "R2 fill before invalidate");
        run_cmd(1, 0, 1, 1, 4, 4, 2, 2, 0, "R4 copy before invalidate");
        @(negedge clk);
        drain_inval = 1'b1;
        @(negedge clk);
        drain_inval = 1'b0;
        chk(drain_valid === 1'b0, "R7 ring discarded", int'(drain_valid), 1'b0);
        @(negedge clk);
        chk(drain_valid === 1'b0, "R7 ring stays empty", int'(drain_valid), 1'b0);
        qn = 0;
        run_cmd(0, 32'h1111_2222, 0, 0, 3, 0, 3, 2, 0, "R3 fill after invalidate");
        drain_check();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule